// File: doc/BRIEF.md
# In-System Programming Sequence Controller

This block runs on the host side. It takes a target device through a complete in-system programming run over a four-wire serial test port. The wires are a shift clock, data toward the target, data back from the target, and a frame-select line. One start pulse launches a run. A mode input decides whether the run programs the array or only checks it.

A full run passes through six stages in a fixed order:

1. A settle interval.
2. A read of the target's identity code.
3. A bulk erase.
4. A write pass over every array address.
5. A readback pass over every array address.
6. A closing settle interval.

A check-only run leaves out the erase and the write pass. Long intervals are counted in clock cycles and scaled from the clock frequency parameter. The write pass and the readback pass each fetch their words from a simple request port. The readback pass compares each returned word and records the first address that differs. An identity mismatch abandons the run and jumps straight to the closing interval.

Every frame starts with a 4-bit opcode, followed by any address and data fields. Each field is sent least-significant bit first.

| Opcode | Use |
|--------|-----|
| 4'hA | identity read |
| 4'h3 | erase |
| 4'h5 | write |
| 4'h6 | read |

Top module: `isp_sequencer`

## Requirements
- R1: A full run presents stage codes in this order: settle 1, identity 2, erase 3, write 4, readback 5, exit 6, finished 7. Idle is 0. The identity stage is one load cycle, then a 2*(4+ID_W)-cycle frame, then one evaluate cycle.
- R2: With `verify_only` high when `start` is taken, stages 3 and 4 never appear. The mode is latched at start, so later changes to `verify_only` have no effect on the run.
- R3: The settle stage lasts exactly CLK_HZ/1000 cycles, which is 1 ms.
- R4: The erase stage is one load cycle, then a 4-bit frame carrying opcode 4'h3, then `strobe` held high for exactly 100 ms of cycles.
- R5: For each address, ascending from 0, the write stage is one load cycle with `word_req` high and `word_addr` equal to that address, then a frame of {data, address, 4'h5}, then `strobe` high for PROG_CYC cycles.
- R6: For each address, the readback stage runs these steps in order:
  - a load cycle with `word_req` high;
  - a frame of {address, 4'h6};
  - `strobe` high for READ_CYC cycles;
  - one idle cycle;
  - a DATA_W-bit capture frame that sends zeros;
  - one evaluate cycle that compares the captured word with the requested word.
- R7: The exit stage lasts exactly CLK_HZ/1000 cycles. The block then shows stage 7 with `done` high and `busy` low.
- R8: If the captured identity word differs from ID_VALUE, `id_error` rises and the run moves straight to the exit stage. No erase or write frame is sent.
- R9: A readback mismatch sets `verify_error`. The flag stays set until the next accepted start. `fail_addr` holds the first failing address in ascending order.
- R10: Each bit takes two cycles:
  - `sck` is low in the first cycle and high in the second;
  - `sdo` is held for both cycles;
  - `sdi` is sampled at the clock edge that ends the high cycle;
  - `sel` is high for exactly 2*n cycles of an n-bit frame.
- R11: `word_data` is taken in the same cycle that `word_req` is high. `sel` is never high in that cycle.
- R12: `start` is ignored while `busy` is high. An accepted start clears `id_error`, `verify_error` and `fail_addr`.
- R13: After reset the outputs show stage 0, with `busy`, `done`, `sel`, `sck`, `sdo`, `strobe` and `word_req` all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when idle or finished |
| verify_only | input | 1 | High selects a check-only run |
| sck | output | 1 | Serial shift clock |
| sdo | output | 1 | Serial data toward the target, LSB first |
| sdi | input | 1 | Serial data from the target |
| sel | output | 1 | High while a frame is being shifted |
| strobe | output | 1 | High during the erase, write and read pulses |
| word_req | output | 1 | Requests the word at `word_addr` this cycle |
| word_addr | output | ADDR_W | Array address being worked on |
| word_data | input | DATA_W | Word for `word_addr`, valid while `word_req` is high |
| stage | output | 3 | Current stage code |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| id_error | output | 1 | The identity check failed |
| verify_error | output | 1 | At least one readback mismatch occurred |
| fail_addr | output | ADDR_W | First address that mismatched |

## Verification
The assertions assume the word source answers combinationally in the cycle that `word_req` is high. They also assume `sdi` is settled before the edge that closes each high phase of `sck`. The bench's target model meets both assumptions: it changes `sdi` only at the falling clock edge inside the high phase, and it derives `word_data` directly from `word_addr`. `start` is driven only between edges. It is raised once in the middle of a run to test that it is ignored. Time is scaled down by setting CLK_HZ to 20 kHz, so 1 ms becomes 20 cycles and the erase pulse becomes 2000 cycles.

// File: rtl/isp_pkg.sv
package isp_pkg;

    // Opcode field leads every frame.
    localparam int OP_W = 4;
    localparam logic [OP_W-1:0] OPC_IDENT = 4'hA;
    localparam logic [OP_W-1:0] OPC_ERASE = 4'h3;
    localparam logic [OP_W-1:0] OPC_WRITE = 4'h5;
    localparam logic [OP_W-1:0] OPC_READ  = 4'h6;

    // Interval lengths in milliseconds.
    localparam int SETTLE_MS = 1;
    localparam int ERASE_MS  = 100;
    localparam int CLOSE_MS  = 1;

    typedef enum logic [2:0] {
        STG_IDLE   = 3'd0,
        STG_SETTLE = 3'd1,
        STG_IDENT  = 3'd2,
        STG_ERASE  = 3'd3,
        STG_WRITE  = 3'd4,
        STG_CHECK  = 3'd5,
        STG_CLOSE  = 3'd6,
        STG_DONE   = 3'd7
    } stage_e;

    typedef enum logic [2:0] {
        SUB_WAIT,
        SUB_LOAD,
        SUB_SHIFT,
        SUB_PULSE,
        SUB_LOAD_CAP,
        SUB_SHIFT_CAP,
        SUB_EVAL
    } sub_e;

    typedef struct packed {
        stage_e stage;
        sub_e   sub;
    } seq_state_t;

    function automatic int ms_cycles(int hz, int ms);
        return (hz / 1000) * ms;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/isp_timer.sv
module isp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter #(
    parameter int MAX_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic [MAX_W-1:0] tx,
    input  logic             sdi,
    output logic             sck,
    output logic             sdo,
    output logic             active,
    output logic             last,
    output logic [MAX_W-1:0] rx
);
    logic [MAX_W-1:0] tx_q, rx_q;
    logic [LEN_W-1:0] left_q;
    logic             phase_q, busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_q    <= '0;
            left_q  <= '0;
            phase_q <= 1'b0;
            busy_q  <= 1'b0;
        end else if (load) begin
            tx_q    <= tx;
            left_q  <= len;
            phase_q <= 1'b0;
            busy_q  <= (len != '0);
        end else if (busy_q) begin
            if (!phase_q) begin
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                tx_q    <= tx_q >> 1;
                rx_q    <= {sdi, rx_q[MAX_W-1:1]};
                left_q  <= left_q - LEN_W'(1);
                if (left_q == LEN_W'(1)) busy_q <= 1'b0;
            end
        end
    end

    assign sck    = busy_q & phase_q;
    assign sdo    = busy_q & tx_q[0];
    assign active = busy_q;
    assign last   = busy_q & phase_q & (left_q == LEN_W'(1));
    assign rx     = rx_q;
endmodule

// File: rtl/isp_sequencer.sv
module isp_sequencer
    import isp_pkg::*;
#(
    parameter int              CLK_HZ   = 50_000_000,
    parameter int              ADDR_W   = 4,
    parameter int              DATA_W   = 16,
    parameter int              ID_W     = 16,
    parameter logic [ID_W-1:0] ID_VALUE = 'hC3A5,
    parameter int              PROG_CYC = 500,
    parameter int              READ_CYC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              verify_only,
    output logic              sck,
    output logic              sdo,
    input  logic              sdi,
    output logic              sel,
    output logic              strobe,
    output logic              word_req,
    output logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] word_data,
    output logic [2:0]        stage,
    output logic              busy,
    output logic              done,
    output logic              id_error,
    output logic              verify_error,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int SETTLE_CYC = ms_cycles(CLK_HZ, SETTLE_MS);
    localparam int ERASE_CYC  = ms_cycles(CLK_HZ, ERASE_MS);
    localparam int CLOSE_CYC  = ms_cycles(CLK_HZ, CLOSE_MS);
    localparam int TMR_MAX    = imax(imax(imax(SETTLE_CYC, CLOSE_CYC), ERASE_CYC),
                                     imax(PROG_CYC, READ_CYC));
    localparam int TMR_W      = $clog2(TMR_MAX + 1);
    localparam int WR_LEN     = OP_W + ADDR_W + DATA_W;
    localparam int RD_LEN     = OP_W + ADDR_W;
    localparam int ID_LEN     = OP_W + ID_W;
    localparam int FRAME_W    = imax(WR_LEN, ID_LEN);
    localparam int LEN_W      = $clog2(FRAME_W + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    seq_state_t        st_q, st_d;
    logic [ADDR_W-1:0] addr_q, addr_d, fail_q;
    logic [DATA_W-1:0] exp_q;
    logic              mode_q, id_err_q, ver_err_q;
    logic              sh_load, sh_last, sh_active;
    logic [LEN_W-1:0]  sh_len;
    logic [FRAME_W-1:0] sh_tx, sh_rx;
    logic              tm_load, tm_zero;
    logic [TMR_W-1:0]  tm_val;
    logic              req, run_go, id_bad, cmp_bad;

    isp_shifter #(.MAX_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .len(sh_len), .tx(sh_tx),
        .sdi(sdi), .sck(sck), .sdo(sdo), .active(sh_active), .last(sh_last),
        .rx(sh_rx)
    );

    isp_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(tm_load), .val(tm_val), .zero(tm_zero)
    );

    always_comb begin
        st_d    = st_q;
        addr_d  = addr_q;
        sh_load = 1'b0;
        sh_len  = '0;
        sh_tx   = '0;
        tm_load = 1'b0;
        tm_val  = '0;
        req     = 1'b0;
        run_go  = 1'b0;
        id_bad  = 1'b0;
        cmp_bad = 1'b0;
        unique case (st_q.stage)
            STG_IDLE, STG_DONE: begin
                if (start) begin
                    run_go  = 1'b1;
                    st_d    = '{STG_SETTLE, SUB_WAIT};
                    tm_load = 1'b1;
                    tm_val  = TMR_W'(SETTLE_CYC - 1);
                end
            end
            STG_SETTLE: begin
                if (tm_zero) st_d = '{STG_IDENT, SUB_LOAD};
            end
            STG_IDENT: begin
                case (st_q.sub)
                    SUB_LOAD: begin
                        sh_load = 1'b1;
                        sh_len  = LEN_W'(ID_LEN);
                        sh_tx   = FRAME_W'(OPC_IDENT);
                        st_d.sub = SUB_SHIFT;
                    end
                    SUB_SHIFT: if (sh_last) st_d.sub = SUB_EVAL;
                    default: begin
                        if ((sh_rx >> (FRAME_W - ID_W)) != FRAME_W'(ID_VALUE)) begin
                            id_bad  = 1'b1;
                            st_d    = '{STG_CLOSE, SUB_WAIT};
                            tm_load = 1'b1;
                            tm_val  = TMR_W'(CLOSE_CYC - 1);
                        end else if (mode_q) begin
                            st_d   = '{STG_CHECK, SUB_LOAD};
                            addr_d = '0;
                        end else begin
                            st_d = '{STG_ERASE, SUB_LOAD};
                        end
                    end
                endcase
            end
            STG_ERASE: begin
                case (st_q.sub)
                    SUB_LOAD: begin
                        sh_load = 1'b1;
                        sh_len  = LEN_W'(OP_W);
                        sh_tx   = FRAME_W'(OPC_ERASE);
                        st_d.sub = SUB_SHIFT;
                    end
                    SUB_SHIFT: begin
                        if (sh_last) begin
                            st_d.sub = SUB_PULSE;
                            tm_load  = 1'b1;
                            tm_val   = TMR_W'(ERASE_CYC - 1);
                        end
                    end
                    default: begin
                        if (tm_zero) begin
                            st_d   = '{STG_WRITE, SUB_LOAD};
                            addr_d = '0;
                        end
                    end
                endcase
            end
            STG_WRITE: begin
                case (st_q.sub)
                    SUB_LOAD: begin
                        req     = 1'b1;
                        sh_load = 1'b1;
                        sh_len  = LEN_W'(WR_LEN);
                        sh_tx   = FRAME_W'({word_data, addr_q, OPC_WRITE});
                        st_d.sub = SUB_SHIFT;
                    end
                    SUB_SHIFT: begin
                        if (sh_last) begin
                            st_d.sub = SUB_PULSE;
                            tm_load  = 1'b1;
                            tm_val   = TMR_W'(PROG_CYC - 1);
                        end
                    end
                    default: begin
                        if (tm_zero) begin
                            if (addr_q == LAST_ADDR) begin
                                st_d   = '{STG_CHECK, SUB_LOAD};
                                addr_d = '0;
                            end else begin
                                st_d.sub = SUB_LOAD;
                                addr_d   = addr_q + ADDR_W'(1);
                            end
                        end
                    end
                endcase
            end
            STG_CHECK: begin
                case (st_q.sub)
                    SUB_LOAD: begin
                        req     = 1'b1;
                        sh_load = 1'b1;
                        sh_len  = LEN_W'(RD_LEN);
                        sh_tx   = FRAME_W'({addr_q, OPC_READ});
                        st_d.sub = SUB_SHIFT;
                    end
                    SUB_SHIFT: begin
                        if (sh_last) begin
                            st_d.sub = SUB_PULSE;
                            tm_load  = 1'b1;
                            tm_val   = TMR_W'(READ_CYC - 1);
                        end
                    end
                    SUB_PULSE: if (tm_zero) st_d.sub = SUB_LOAD_CAP;
                    SUB_LOAD_CAP: begin
                        sh_load  = 1'b1;
                        sh_len   = LEN_W'(DATA_W);
                        st_d.sub = SUB_SHIFT_CAP;
                    end
                    SUB_SHIFT_CAP: if (sh_last) st_d.sub = SUB_EVAL;
                    default: begin
                        cmp_bad = ((sh_rx >> (FRAME_W - DATA_W)) != FRAME_W'(exp_q));
                        if (addr_q == LAST_ADDR) begin
                            st_d    = '{STG_CLOSE, SUB_WAIT};
                            tm_load = 1'b1;
                            tm_val  = TMR_W'(CLOSE_CYC - 1);
                        end else begin
                            st_d.sub = SUB_LOAD;
                            addr_d   = addr_q + ADDR_W'(1);
                        end
                    end
                endcase
            end
            STG_CLOSE: begin
                if (tm_zero) st_d = '{STG_DONE, SUB_WAIT};
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '{STG_IDLE, SUB_WAIT};
            addr_q    <= '0;
            fail_q    <= '0;
            exp_q     <= '0;
            mode_q    <= 1'b0;
            id_err_q  <= 1'b0;
            ver_err_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            if (run_go) begin
                mode_q    <= verify_only;
                id_err_q  <= 1'b0;
                ver_err_q <= 1'b0;
                fail_q    <= '0;
            end
            if (id_bad) id_err_q <= 1'b1;
            if (cmp_bad && !ver_err_q) begin
                ver_err_q <= 1'b1;
                fail_q    <= addr_q;
            end
            if (req && st_q.stage == STG_CHECK) exp_q <= word_data;
        end
    end

    assign sel          = sh_active;
    assign strobe       = (st_q.sub == SUB_PULSE);
    assign word_req     = req;
    assign word_addr    = addr_q;
    assign stage        = st_q.stage;
    assign busy         = (st_q.stage != STG_IDLE) && (st_q.stage != STG_DONE);
    assign done         = (st_q.stage == STG_DONE);
    assign id_error     = id_err_q;
    assign verify_error = ver_err_q;
    assign fail_addr    = fail_q;
endmodule

// File: rtl/isp_sequencer_chk.sv
module isp_sequencer_chk
    import isp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        stage,
    input logic              sel,
    input logic              sck,
    input logic              sdo,
    input logic              strobe,
    input logic              word_req,
    input logic              busy,
    input logic              done,
    input logic              id_error,
    input logic              verify_error,
    input logic [ADDR_W-1:0] fail_addr,
    input logic              mode_q
);
    // Pulse and frame never overlap (R4, R5, R6).
    p_pulse_not_shift_r4: assert property (@(posedge clk) disable iff (rst)
        !(strobe && sel));

    // Data held through the high half of each bit (R10).
    p_sdo_held_r10: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(sdo));

    // High half of a bit lasts one cycle (R10).
    p_sck_one_high_r10: assert property (@(posedge clk) disable iff (rst)
        sck |=> !sck);

    // Shift clock only inside a frame (R10).
    p_sck_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
        sck |-> sel);

    // Identity failure goes straight to the exit stage (R8).
    p_id_fail_exit_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(id_error) |-> stage == STG_CLOSE);

    // Mismatch record is sticky until a new start (R9).
    p_verr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (verify_error && !start) |=> (verify_error && $stable(fail_addr)));

    // Check-only mode never enters erase or write (R2).
    p_mode_skips_r2: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> (stage != STG_ERASE && stage != STG_WRITE));

    // Word request never coincides with shifting (R11).
    p_req_idle_line_r11: assert property (@(posedge clk) disable iff (rst)
        word_req |-> !sel);

    // Finished state is quiet (R7).
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !sel && !strobe));
endmodule

bind isp_sequencer isp_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .stage(stage), .sel(sel), .sck(sck),
    .sdo(sdo), .strobe(strobe), .word_req(word_req), .busy(busy), .done(done),
    .id_error(id_error), .verify_error(verify_error), .fail_addr(fail_addr),
    .mode_q(mode_q)
);

// File: tb/isp_sequencer_bench.sv
module isp_sequencer_bench;
    import isp_pkg::*;

    // Scaled time base: 20 kHz nominal makes 1 ms equal to 20 cycles.
    localparam int HZ  = 20_000;
    localparam int AW  = 3;
    localparam int DW  = 8;
    localparam int IW  = 8;
    localparam logic [IW-1:0] IDV = 8'h5A;
    localparam int PC  = 6;
    localparam int RC  = 3;
    localparam int NW  = 1 << AW;
    localparam int MS  = HZ / 1000;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, verify_only = 1'b0, sdi = 1'b0;
    logic sck, sdo, sel, strobe, word_req, busy, done, id_error, verify_error;
    logic [AW-1:0] word_addr, fail_addr;
    logic [DW-1:0] word_data;
    logic [2:0]    stage;

    always #10 clk = ~clk;

    isp_sequencer #(.CLK_HZ(HZ), .ADDR_W(AW), .DATA_W(DW), .ID_W(IW),
                    .ID_VALUE(IDV), .PROG_CYC(PC), .READ_CYC(RC)) u_isp_sequencer (
        .clk(clk), .rst(rst), .start(start), .verify_only(verify_only),
        .sck(sck), .sdo(sdo), .sdi(sdi), .sel(sel), .strobe(strobe),
        .word_req(word_req), .word_addr(word_addr), .word_data(word_data),
        .stage(stage), .busy(busy), .done(done), .id_error(id_error),
        .verify_error(verify_error), .fail_addr(fail_addr)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;

    function automatic logic [DW-1:0] pattern(int a);
        return DW'(a * 29 + 7);
    endfunction

    assign word_data = pattern(int'(word_addr));

    // Behavioural target: decodes frames, holds an array, answers reads.
    logic [DW-1:0] mem [NW];
    logic [IW-1:0] id_resp = IDV;
    logic [31:0]   fbuf;
    int            fcnt = 0, n_erase = 0, n_badframe = 0;
    int            bad_a0 = -1, bad_a1 = -1;
    logic [AW-1:0] raddr = '0;
    bit            in_rd = 1'b0;

    always @(negedge clk) begin
        if (sel && sck) begin
            if (stage == STG_IDENT)
                sdi = (fcnt >= OP_W) ? id_resp[fcnt-OP_W] : 1'b0;
            else if (in_rd)
                sdi = mem[raddr][fcnt] ^ (((int'(raddr) == bad_a0) || (int'(raddr) == bad_a1)) && fcnt == 0);
            else
                sdi = 1'b0;
            fbuf[fcnt] = sdo;
            fcnt++;
        end else if (!sel && fcnt > 0) begin
            if (in_rd) begin
                in_rd = 1'b0;
                if (fcnt != DW) n_badframe++;
            end else if (fbuf[3:0] == OPC_ERASE && fcnt == OP_W) begin
                for (int i = 0; i < NW; i++) mem[i] = '1;
                n_erase++;
            end else if (fbuf[3:0] == OPC_WRITE && fcnt == OP_W + AW + DW) begin
                mem[fbuf[OP_W +: AW]] = fbuf[OP_W+AW +: DW];
            end else if (fbuf[3:0] == OPC_READ && fcnt == OP_W + AW) begin
                raddr = fbuf[OP_W +: AW];
                in_rd = 1'b1;
            end else if (!(fbuf[3:0] == OPC_IDENT && fcnt == OP_W + IW)) begin
                n_badframe++;
            end
            fcnt = 0;
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected per-cycle trace, built as segments.
    typedef struct {
        logic [2:0]    stg;
        bit            sl;
        bit            st;
        bit            rq;
        logic [AW-1:0] ad;
        int            len;
        string         tag;
    } seg_t;
    seg_t segs[$];

    function automatic void push(logic [2:0] s, bit sl, bit st, bit rq, int a, int len, string tag);
        seg_t x;
        x.stg = s; x.sl = sl; x.st = st; x.rq = rq; x.ad = AW'(a); x.len = len; x.tag = tag;
        segs.push_back(x);
    endfunction

    task automatic run(bit vo, bit id_ok, bit poke);
        int cyc = 0;
        string t;
        segs.delete();
        push(STG_SETTLE, 0, 0, 0, 0, MS, "R3");
        push(STG_IDENT, 0, 0, 0, 0, 1, "R1");
        push(STG_IDENT, 1, 0, 0, 0, 2 * (OP_W + IW), "R10");
        push(STG_IDENT, 0, 0, 0, 0, 1, "R1");
        if (id_ok) begin
            if (!vo) begin
                push(STG_ERASE, 0, 0, 0, 0, 1, "R4");
                push(STG_ERASE, 1, 0, 0, 0, 2 * OP_W, "R4");
                push(STG_ERASE, 0, 1, 0, 0, 100 * MS, "R4");
                for (int a = 0; a < NW; a++) begin
                    push(STG_WRITE, 0, 0, 1, a, 1, "R5");
                    push(STG_WRITE, 1, 0, 0, a, 2 * (OP_W + AW + DW), "R5");
                    push(STG_WRITE, 0, 1, 0, a, PC, "R5");
                end
            end
            for (int a = 0; a < NW; a++) begin
                t = vo ? "R2" : "R6";
                push(STG_CHECK, 0, 0, 1, a, 1, t);
                push(STG_CHECK, 1, 0, 0, a, 2 * (OP_W + AW), t);
                push(STG_CHECK, 0, 1, 0, a, RC, t);
                push(STG_CHECK, 0, 0, 0, a, 1, t);
                push(STG_CHECK, 1, 0, 0, a, 2 * DW, t);
                push(STG_CHECK, 0, 0, 0, a, 1, t);
            end
        end else begin
            t = "R8";
        end
        push(STG_CLOSE, 0, 0, 0, 0, MS, "R7");

        @(negedge clk);
        verify_only = vo;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        verify_only = ~vo; // latched at start, must not matter (R2)
        chk(!id_error && !verify_error && fail_addr == '0, "R12", "flags cleared on start",
            {id_error, verify_error, fail_addr}, 0);
        foreach (segs[i]) begin
            for (int k = 0; k < segs[i].len; k++) begin
                chk({stage, sel, strobe, word_req} == {segs[i].stg, segs[i].sl, segs[i].st, segs[i].rq},
                    segs[i].tag, "stage/sel/strobe/req",
                    {stage, sel, strobe, word_req}, {segs[i].stg, segs[i].sl, segs[i].st, segs[i].rq});
                if (segs[i].rq)
                    chk(word_addr == segs[i].ad, "R11", "word_addr", word_addr, segs[i].ad);
                chk(busy && !done, "R1", "busy during run", {busy, done}, 2'b10);
                if (poke && cyc == 6)
                    chk(stage == STG_SETTLE, "R12", "start ignored while busy", stage, STG_SETTLE);
                start = (poke && cyc == 5);
                cyc++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(stage == STG_DONE && done && !busy, "R7", "finished state",
            {stage, done, busy}, {STG_DONE, 2'b10});
        chk(n_badframe == 0, "R10", "malformed frames seen by target", n_badframe, 0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: reset state
        chk(stage == STG_IDLE && !busy && !done, "R13", "stage/busy/done", {stage, busy, done}, 0);
        chk(!sel && !sck && !sdo && !strobe && !word_req, "R13", "serial lines idle",
            {sel, sck, sdo, strobe, word_req}, 0);
        repeat (4) @(negedge clk);
        chk(stage == STG_IDLE, "R13", "stays idle without start", stage, STG_IDLE);

        // Full run, good identity, stray start mid-run.
        run(1'b0, 1'b1, 1'b1);
        chk(n_erase == 1, "R4", "erase frames", n_erase, 1);
        for (int a = 0; a < NW; a++)
            chk(mem[a] == pattern(a), "R5", $sformatf("written word %0d", a), mem[a], pattern(a));
        chk(!verify_error && !id_error, "R6", "clean readback flags", {verify_error, id_error}, 0);

        // Check-only run with two corrupted readbacks.
        bad_a0 = 6; bad_a1 = 2;
        run(1'b1, 1'b1, 1'b0);
        chk(verify_error, "R9", "mismatch flag", verify_error, 1);
        chk(fail_addr == AW'(2), "R9", "first failing address", fail_addr, 2);
        chk(!id_error, "R9", "no identity error", id_error, 0);
        chk(n_erase == 1, "R2", "no erase in check-only run", n_erase, 1);
        repeat (3) @(negedge clk);
        chk(verify_error && fail_addr == AW'(2), "R9", "flag sticky after done",
            {verify_error, fail_addr}, {1'b1, AW'(2)});
        bad_a0 = -1; bad_a1 = -1;

        // Full run with a wrong identity word.
        id_resp = IDV ^ 8'h01;
        run(1'b0, 1'b0, 1'b0);
        chk(id_error, "R8", "identity error flag", id_error, 1);
        chk(!verify_error, "R12", "mismatch flag cleared", verify_error, 0);
        chk(n_erase == 1, "R8", "no erase after identity failure", n_erase, 1);
        for (int a = 0; a < NW; a++)
            chk(mem[a] == pattern(a), "R8", $sformatf("array untouched %0d", a), mem[a], pattern(a));
        id_resp = IDV;

        // Clean check-only run.
        run(1'b1, 1'b1, 1'b0);
        chk(!verify_error && !id_error, "R2", "clean check-only run", {verify_error, id_error}, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule